// File: doc/BRIEF.md
# Synthesizer Configuration Word Loader

This block keeps the configuration word of a clock synthesizer: a 7-bit feedback multiplier, a 2-bit post-divider code and a 3-bit test-output select. The word can be written over two paths. A three-wire serial path has a bit clock, a data line and a load strobe. It fills a 12-bit shift register, and the register is committed to the output latches when the load strobe falls. A parallel path presents the multiplier and divider on pins, and they are committed when the parallel strobe rises. The parallel path has priority. While its strobe is low, serial commits are refused, so holding that strobe low through reset and releasing it once the pins are valid brings up a known configuration.

All strobes and data pins enter through two-flop synchronisers and are edge-detected in the system clock domain. A four-state machine decides which commit, if any, happens:
- **ST_HOLD**: the parallel strobe is low. Serial commits are refused. A rising parallel strobe (`hold_to_pload`) moves to ST_PLOAD.
- **ST_PLOAD**: the multiplier and divider are written from the captured pins. The select field is kept. This state leaves by `pload_to_hold` if the strobe is low, by `pload_to_sload` if a serial fall arrives, and by `pload_to_armed` otherwise.
- **ST_ARMED**: the parallel strobe is high and serial commits are accepted. This state leaves by `armed_to_hold` when the strobe drops and by `armed_to_sload` on a serial fall.
- **ST_SLOAD**: all three fields are written from the captured shift word. This state leaves by `sload_to_hold`, `sload_to_sload` or `sload_to_armed`, under the same conditions as ST_PLOAD.

Top module: `synth_cfg_loader`

## Requirements
- R1: After reset, `mult_q`, `div_q` and `tsel_q` are zero and `cfg_valid` is low.
- R2: A rising edge on `par_strobe` loads `mult_q` from `par_mult` and `div_q` from `par_div`, and leaves `tsel_q` unchanged.
- R3: A falling edge on `ser_strobe` while `par_strobe` is high loads the last 12 bits shifted in. Bits are shifted MSB first on rising edges of `ser_clk`, and the field order from the first bit to the last is select[2:0], divider[1:0], multiplier[6:0].
- R4: A falling edge on `ser_strobe` while `par_strobe` is low leaves all outputs and `cfg_valid` unchanged.
- R5: When a parallel rise and a serial fall are seen together, the parallel values are loaded and `tsel_q` is kept.
- R6: When more than 12 bits are shifted before a commit, only the last 12 bits count.
- R7: `cfg_valid` goes high after the first commit of either kind and stays high until reset.
- R8: The outputs change only on a commit. A rising `ser_strobe` and a falling `par_strobe` cause no change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock; the register shifts on its rising edge |
| ser_data | input | 1 | Serial data bit |
| ser_strobe | input | 1 | Serial commit strobe; acts on its falling edge |
| par_strobe | input | 1 | Parallel commit strobe; acts on its rising edge; when low, blocks serial commits |
| par_mult | input | 7 | Parallel multiplier value |
| par_div | input | 2 | Parallel divider code |
| mult_q | output | 7 | Latched multiplier |
| div_q | output | 2 | Latched divider code |
| tsel_q | output | 3 | Latched test-output select |
| cfg_valid | output | 1 | High once any commit has occurred |

## Verification
The assertions check on every cycle that the outputs hold steady outside the commit states, that a parallel commit keeps the select field, that `cfg_valid` follows a commit and then stays high, and that a parallel rise seen in ST_HOLD always wins the arbitration. Only the bench scenarios can show the actual field values. These include the serial bit order and field split, the last-12-bits behaviour of an over-long shift, the refused serial commit while the parallel strobe is low, and the tie between the two strobes.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    localparam int MULT_W = 7;
    localparam int DIV_W  = 2;
    localparam int TSEL_W = 3;
    localparam int WORD_W = TSEL_W + DIV_W + MULT_W;

    // First-shifted field sits at the top of the word.
    typedef struct packed {
        logic [TSEL_W-1:0] tsel;
        logic [DIV_W-1:0]  div;
        logic [MULT_W-1:0] mult;
    } cfg_word_t;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_PLOAD = 2'd1,
        ST_ARMED = 2'd2,
        ST_SLOAD = 2'd3
    } cfg_state_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
        end else begin
            chain_q[0] <= din;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_edge.sv
module cfg_edge #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_edge
        logic prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= level[g];
        end
        assign rise[g] = level[g] & ~prev_q;
        assign fall[g] = ~level[g] & prev_q;
    end
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {word[WIDTH-2:0], bit_in};
    end
endmodule

// File: rtl/cfg_fsm.sv
module cfg_fsm
    import cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_level,
    input  logic              par_rise,
    input  logic              ser_fall,
    input  logic [MULT_W-1:0] par_mult,
    input  logic [DIV_W-1:0]  par_div,
    input  cfg_word_t         ser_word,
    output cfg_state_e        state,
    output logic [MULT_W-1:0] mult_q,
    output logic [DIV_W-1:0]  div_q,
    output logic [TSEL_W-1:0] tsel_q,
    output logic              valid_q
);
    cfg_state_e        nxt;
    logic [MULT_W-1:0] stage_mult;
    logic [DIV_W-1:0]  stage_div;
    cfg_word_t         stage_ser;

    // Next-state decision: parallel rise wins whenever it is seen.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_HOLD: begin
                if (par_rise) nxt = ST_PLOAD;      // hold_to_pload
            end
            ST_PLOAD, ST_SLOAD: begin
                if (!par_level)    nxt = ST_HOLD;  // *_to_hold
                else if (ser_fall) nxt = ST_SLOAD; // *_to_sload
                else               nxt = ST_ARMED; // *_to_armed
            end
            ST_ARMED: begin
                if (!par_level)    nxt = ST_HOLD;  // armed_to_hold
                else if (ser_fall) nxt = ST_SLOAD; // armed_to_sload
            end
            default: nxt = ST_HOLD;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= nxt;
    end

    // Snapshot of the source values at the moment the event is accepted.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_mult <= '0;
            stage_div  <= '0;
            stage_ser  <= '0;
        end else begin
            if (nxt == ST_PLOAD) begin
                stage_mult <= par_mult;
                stage_div  <= par_div;
            end
            if (nxt == ST_SLOAD) stage_ser <= ser_word;
        end
    end

    // Output latches, written only in the commit states.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mult_q  <= '0;
            div_q   <= '0;
            tsel_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            unique case (state)
                ST_PLOAD: begin
                    mult_q  <= stage_mult;
                    div_q   <= stage_div;
                    valid_q <= 1'b1;
                end
                ST_SLOAD: begin
                    mult_q  <= stage_ser.mult;
                    div_q   <= stage_ser.div;
                    tsel_q  <= stage_ser.tsel;
                    valid_q <= 1'b1;
                end
                ST_HOLD, ST_ARMED: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
    import cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_strobe,
    input  logic              par_strobe,
    input  logic [MULT_W-1:0] par_mult,
    input  logic [DIV_W-1:0]  par_div,
    output logic [MULT_W-1:0] mult_q,
    output logic [DIV_W-1:0]  div_q,
    output logic [TSEL_W-1:0] tsel_q,
    output logic              cfg_valid
);
    localparam int NUM_STROBES = 3;
    localparam int BUS_W       = NUM_STROBES + 1 + MULT_W + DIV_W;

    logic [BUS_W-1:0]       raw_bus, sync_bus;
    logic [NUM_STROBES-1:0] strobe_lvl, strobe_rise, strobe_fall;
    logic                   data_s;
    logic [MULT_W-1:0]      mult_s;
    logic [DIV_W-1:0]       div_s;
    logic                   par_rise, ser_fall, bit_tick;
    logic [WORD_W-1:0]      shift_word;
    cfg_state_e             cur_state;
    logic                   unused_edges;

    assign raw_bus = {par_strobe, ser_strobe, ser_clk, ser_data, par_mult, par_div};

    cfg_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .din(raw_bus), .dout(sync_bus)
    );

    assign {strobe_lvl, data_s, mult_s, div_s} = sync_bus;

    cfg_edge #(.WIDTH(NUM_STROBES)) i_edge (
        .clk(clk), .rst_n(rst_n), .level(strobe_lvl),
        .rise(strobe_rise), .fall(strobe_fall)
    );

    // strobe_lvl[2]=parallel strobe, [1]=serial strobe, [0]=bit clock
    assign par_rise     = strobe_rise[2];
    assign ser_fall     = strobe_fall[1];
    assign bit_tick     = strobe_rise[0];
    assign unused_edges = ^{strobe_rise[1], strobe_fall[2], strobe_fall[0]};

    cfg_shift #(.WIDTH(WORD_W)) i_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(bit_tick),
        .bit_in(data_s), .word(shift_word)
    );

    cfg_fsm i_fsm (
        .clk(clk), .rst_n(rst_n),
        .par_level(strobe_lvl[2]), .par_rise(par_rise), .ser_fall(ser_fall),
        .par_mult(mult_s), .par_div(div_s), .ser_word(cfg_word_t'(shift_word)),
        .state(cur_state), .mult_q(mult_q), .div_q(div_q), .tsel_q(tsel_q),
        .valid_q(cfg_valid)
    );
endmodule

// File: rtl/synth_cfg_loader_chk.sv
module synth_cfg_loader_chk
    import cfg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input cfg_state_e        state,
    input logic              par_rise,
    input logic [MULT_W-1:0] mult_q,
    input logic [DIV_W-1:0]  div_q,
    input logic [TSEL_W-1:0] tsel_q,
    input logic              cfg_valid
);
    logic in_commit;
    assign in_commit = (state == ST_PLOAD) || (state == ST_SLOAD);

    p_stable_outside_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_commit |=> $stable({mult_q, div_q, tsel_q, cfg_valid}));

    p_tsel_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PLOAD) |=> $stable(tsel_q));

    p_valid_after_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_commit |=> cfg_valid);

    p_valid_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> cfg_valid);

    p_par_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && par_rise) |=> (state == ST_PLOAD));

    p_no_serial_in_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |=> (state != ST_SLOAD));
endmodule

bind synth_cfg_loader synth_cfg_loader_chk i_chk (
    .clk(clk), .rst_n(rst_n), .state(cur_state), .par_rise(par_rise),
    .mult_q(mult_q), .div_q(div_q), .tsel_q(tsel_q), .cfg_valid(cfg_valid)
);

// File: tb/test_synth_cfg_loader.sv
module test_synth_cfg_loader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0, ser_data = 1'b0, ser_strobe = 1'b0, par_strobe = 1'b0;
    logic [6:0] par_mult = '0;
    logic [1:0] par_div = '0;
    logic [6:0] mult_q;
    logic [1:0] div_q;
    logic [2:0] tsel_q;
    logic       cfg_valid;

    int compared = 0;
    int mismatched = 0;
    logic [6:0] exp_m = '0;
    logic [1:0] exp_n = '0;
    logic [2:0] exp_t = '0;
    logic       exp_v = 1'b0;

    always #5 clk = ~clk;

    synth_cfg_loader i_synth_cfg_loader (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_strobe(ser_strobe), .par_strobe(par_strobe), .par_mult(par_mult),
        .par_div(par_div), .mult_q(mult_q), .div_q(div_q), .tsel_q(tsel_q),
        .cfg_valid(cfg_valid)
    );

    function automatic logic [12:0] pack_exp(logic [6:0] m, logic [1:0] n, logic [2:0] t, logic v);
        return {t, n, m, v};
    endfunction

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req);
        logic [12:0] got, exp;
        got = {tsel_q, div_q, mult_q, cfg_valid};
        exp = pack_exp(exp_m, exp_n, exp_t, exp_v);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got t=%0d n=%0d m=%0d v=%0b expected t=%0d n=%0d m=%0d v=%0b",
                     req, got[12:10], got[9:8], got[7:1], got[0],
                     exp[12:10], exp[9:8], exp[7:1], exp[0]);
        end
    endtask

    task automatic shift_bits(logic [15:0] bits, int count);
        for (int i = count - 1; i >= 0; i--) begin
            ser_data = bits[i];
            wait_cyc(4);
            ser_clk = 1'b1;
            wait_cyc(4);
            ser_clk = 1'b0;
            wait_cyc(4);
        end
    endtask

    task automatic ser_commit();
        ser_strobe = 1'b1;
        wait_cyc(5);
        ser_strobe = 1'b0;
        wait_cyc(8);
    endtask

    task automatic par_commit(logic [6:0] m, logic [1:0] n);
        par_strobe = 1'b0;
        wait_cyc(5);
        par_mult = m;
        par_div  = n;
        wait_cyc(5);
        par_strobe = 1'b1;
        wait_cyc(8);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [11:0] w;
        void'($urandom(32'd4242));
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(4);
        check("R1 reset state");

        // R4: serial commit refused while par_strobe is low
        shift_bits(16'h0ABC, 12);
        ser_commit();
        check("R4 serial ignored while parallel strobe low");

        // R2 / R7: first parallel commit
        par_mult = 7'd45; par_div = 2'd2;
        wait_cyc(5);
        par_strobe = 1'b1;
        wait_cyc(8);
        exp_m = 7'd45; exp_n = 2'd2; exp_v = 1'b1;
        check("R2 parallel commit, R7 valid set");

        // R3: serial commit with par_strobe high
        w = {3'd5, 2'd1, 7'd99};
        shift_bits({4'h0, w}, 12);
        ser_commit();
        exp_t = 3'd5; exp_n = 2'd1; exp_m = 7'd99;
        check("R3 serial field order");

        // R2: parallel commit keeps tsel
        par_commit(7'd17, 2'd3);
        exp_m = 7'd17; exp_n = 2'd3;
        check("R2 parallel keeps select");

        // R6: 15 bits shifted, only last 12 count
        shift_bits({1'b0, 3'b111, 3'd2, 2'd0, 7'd120}, 15);
        ser_commit();
        exp_t = 3'd2; exp_n = 2'd0; exp_m = 7'd120;
        check("R6 over-long shift");

        // R8: serial strobe rise alone, parallel fall alone
        ser_strobe = 1'b1;
        wait_cyc(10);
        check("R8 serial strobe rise no change");
        ser_strobe = 1'b0;
        wait_cyc(8);
        exp_t = 3'd2; exp_n = 2'd0; exp_m = 7'd120;
        check("R3 commit on later fall");
        par_mult = 7'd3; par_div = 2'd1;
        par_strobe = 1'b0;
        wait_cyc(10);
        check("R8 parallel strobe fall no change");

        // R5: simultaneous parallel rise and serial fall
        shift_bits({4'h0, 3'd7, 2'd2, 7'd64}, 12);
        ser_strobe = 1'b1;
        wait_cyc(5);
        par_strobe = 1'b1;
        ser_strobe = 1'b0;
        wait_cyc(10);
        exp_m = 7'd3; exp_n = 2'd1;
        check("R5 parallel wins tie");

        // Random mix
        for (int it = 0; it < 24; it++) begin
            int kind;
            kind = int'($urandom % 3);
            w = 12'($urandom);
            if (kind == 0) begin
                shift_bits({4'h0, w}, 12);
                ser_commit();
                exp_t = w[11:9]; exp_n = w[8:7]; exp_m = w[6:0];
                check("R3 random serial");
            end else if (kind == 1) begin
                par_commit(w[6:0], w[8:7]);
                exp_m = w[6:0]; exp_n = w[8:7];
                check("R2 random parallel");
            end else begin
                par_strobe = 1'b0;
                par_mult = w[10:4]; par_div = w[1:0];
                shift_bits({4'h0, ~w}, 12);
                ser_commit();
                check("R4 random refused serial");
                par_strobe = 1'b1;
                wait_cyc(8);
                exp_m = w[10:4]; exp_n = w[1:0];
                check("R2 random release");
            end
        end

        // R7 / R1: valid stays until reset
        rst_n = 1'b0;
        wait_cyc(3);
        exp_m = '0; exp_n = '0; exp_t = '0; exp_v = 1'b0;
        check("R7 valid cleared only by reset, R1");
        par_strobe = 1'b0;
        rst_n = 1'b1;
        wait_cyc(8);
        check("R1 after reset release");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule